// File: doc/BRIEF.md
# Per-Thread Hardware Stack Bank with Sticky Error Flags

This block holds the hardware data stacks of a barrel-style multithreaded processor. Each of eight threads owns four stacks, and each stack is 32 entries deep. In any cycle the issuing thread names one of its stacks with a 2-bit select and can push, pop, or pop and push at once. It can also empty all four of its own stacks with a single clear command. The top of the selected stack is always visible on a combinational output.

Stack misuse is not hidden. A push into a full stack or a pop from an empty stack leaves the stack safe and sets a sticky bit for that thread in a shared 16-bit error register. Software reads the register and clears chosen bits by writing a mask of ones. All stack words sit in one memory addressed by thread, stack and pointer. Each (thread, stack) pair has its own fill-level counter.

Top module: `thread_stack_bank`

## Requirements
- R1: From empty, 32 pushes to a stack succeed without setting any error bit, and after each push `topData` shows the value just pushed.
- R2: A push without a pop on a stack holding 32 entries sets error bit 8+thread, and leaves the stack's contents, its level and `topData` unchanged.
- R3: A push and a pop in the same cycle on a non-empty stack (full stacks included) replace the top entry with the pushed value, keep the level, and set no error bit.
- R4: A pop on a non-empty stack removes the top entry. A pop on an empty stack sets error bit thread (bits 7:0 are pop errors) and leaves the level at zero. A push and a pop together on an empty stack set that same bit and store the pushed value as the only entry.
- R5: Error bits are sticky. A set bit stays at 1 until software clears it.
- R6: When `errWrEn` is high, each bit of the error register whose bit in `errWrMask` is 1 is cleared at the clock edge. All other bits keep their values.
- R7: If an error bit is set and cleared by a mask write in the same cycle, it ends the cycle at 1.
- R8: `clrStacks` empties all four stacks of the thread on `thrdId` and ignores any push or pop in that cycle. Other threads' stacks are not affected. A cleared stack can then take 32 pushes without error.
- R9: The 32 stacks are independent. An operation touches only the stack chosen by `thrdId` and `stkSel`, and sets only the error bit of `thrdId`.
- R10: After reset the error register is zero and every stack is empty. An empty selected stack drives `topData` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| thrdId | input | 3 | Issuing thread |
| stkSel | input | 2 | Stack select within the thread |
| pushEn | input | 1 | Push strobe |
| popEn | input | 1 | Pop strobe |
| pushData | input | 32 | Value to push |
| clrStacks | input | 1 | Empty all stacks of the issuing thread |
| errWrEn | input | 1 | Error register write strobe |
| errWrMask | input | 16 | Write-one-to-clear mask |
| topData | output | 32 | Top entry of the selected stack, zero when empty |
| errReg | output | 16 | Error register: [15:8] push errors, [7:0] pop errors |

## Verification
The assertions watch several properties on every cycle. A level never goes above the depth. A lone push into a full stack raises the push flag, and a pop on an empty stack raises the pop flag, one cycle later. A pop-and-push keeps the level. A clear leaves the selected stack empty. Error bits fall only when a mask write is in progress. Contents-level behaviour needs the bench's scenarios: that a refused push keeps the old data, that the top entry is replaced in place, the exact error-register values, and that a bit being set wins over a clear in the same cycle. The bench also runs a random mix against a bench-side reference model to show that stacks and threads stay independent.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  localparam int NTHREADS = 8;
  localparam int NSTACKS  = 4;
  localparam int DEPTH    = 32;
  localparam int DATA_W   = 32;

  localparam int TID_W  = $clog2(NTHREADS);
  localparam int SEL_W  = $clog2(NSTACKS);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int LVL_W  = PTR_W + 1;
  localparam int SLOT_W = TID_W + SEL_W;
  localparam int ADDR_W = SLOT_W + PTR_W;
  localparam int ERR_W  = 2 * NTHREADS;
  localparam int NSLOTS = NTHREADS * NSTACKS;
  localparam int NWORDS = NSLOTS * DEPTH;

  // strobes from control to the storage datapath
  typedef struct packed {
    logic              memWr;
    logic [ADDR_W-1:0] wrAddr;
    logic              topValid;
    logic [ADDR_W-1:0] rdAddr;
  } memStrobes_t;

  function automatic logic [ADDR_W-1:0] packAddr(input logic [SLOT_W-1:0] slot,
                                                 input logic [PTR_W-1:0] ptr);
    return {slot, ptr};
  endfunction
endpackage

// File: rtl/tsb_ctrl.sv
module tsb_ctrl
  import tsb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [TID_W-1:0]  thrdId,
  input  logic [SEL_W-1:0]  stkSel,
  input  logic              pushEn,
  input  logic              popEn,
  input  logic              clrStacks,
  input  logic              errWrEn,
  input  logic [ERR_W-1:0]  errWrMask,
  output memStrobes_t       strobes,
  output logic [ERR_W-1:0]  errReg
);
  logic [LVL_W-1:0] level [NSLOTS];
  logic [SLOT_W-1:0] curSlot;
  logic [LVL_W-1:0]  curLvl, lvlDec, nextLvl;
  logic              isFull, isEmpty;
  logic              doWr, pushErr, popErr;
  logic [PTR_W-1:0]  wrPtr;
  logic [NTHREADS-1:0] popSet, pushSet;
  logic [ERR_W-1:0]  errSet, clrMask;

  assign curSlot = {thrdId, stkSel};
  assign curLvl  = level[curSlot];
  assign lvlDec  = curLvl - LVL_W'(1);
  assign isFull  = (curLvl == LVL_W'(DEPTH));
  assign isEmpty = (curLvl == '0);

  always_comb begin
    doWr    = 1'b0;
    wrPtr   = curLvl[PTR_W-1:0];
    nextLvl = curLvl;
    pushErr = 1'b0;
    popErr  = 1'b0;
    if (!clrStacks) begin
      unique case ({pushEn, popEn})
        2'b10: begin
          if (isFull) pushErr = 1'b1;
          else begin
            doWr    = 1'b1;
            nextLvl = curLvl + LVL_W'(1);
          end
        end
        2'b01: begin
          if (isEmpty) popErr = 1'b1;
          else nextLvl = lvlDec;
        end
        2'b11: begin
          doWr = 1'b1;
          if (isEmpty) begin
            popErr  = 1'b1;
            wrPtr   = '0;
            nextLvl = LVL_W'(1);
          end else begin
            wrPtr = lvlDec[PTR_W-1:0];
          end
        end
        default: ;
      endcase
    end
  end

  // level counters: clear of the issuing thread wins over per-slot update
  always_ff @(posedge clk) begin
    for (int i = 0; i < NSLOTS; i++) begin
      if (!rstN) level[i] <= '0;
      else if (clrStacks && ((i / NSTACKS) == int'(thrdId))) level[i] <= '0;
      else if (i == int'(curSlot)) level[i] <= nextLvl;
    end
  end

  always_comb begin
    popSet  = '0;
    pushSet = '0;
    popSet[thrdId]  = popErr;
    pushSet[thrdId] = pushErr;
    errSet  = {pushSet, popSet};
    clrMask = errWrEn ? errWrMask : '0;
  end

  // sticky write-one-to-clear, set wins
  always_ff @(posedge clk) begin
    if (!rstN) errReg <= '0;
    else       errReg <= (errReg & ~clrMask) | errSet;
  end

  assign strobes.memWr    = doWr;
  assign strobes.wrAddr   = packAddr(curSlot, wrPtr);
  assign strobes.topValid = !isEmpty;
  assign strobes.rdAddr   = packAddr(curSlot, lvlDec[PTR_W-1:0]);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    curLvl <= LVL_W'(DEPTH)); // R2
  AST_PUSH_FULL_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && !popEn && !clrStacks && isFull) |=> errReg[NTHREADS + int'($past(thrdId))]); // R2
  AST_POP_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !clrStacks && isEmpty) |=> errReg[$past(thrdId)]); // R4
  AST_SWAP_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && popEn && !clrStacks && !isEmpty) |=> (level[$past(curSlot)] == $past(curLvl))); // R3
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    clrStacks |=> (level[$past(curSlot)] == '0)); // R8
  AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rstN)
    !errWrEn |=> ((errReg & $past(errReg)) == $past(errReg))); // R5
endmodule

// File: rtl/tsb_datapath.sv
module tsb_datapath
  import tsb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  memStrobes_t       strobes,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] topData
);
  logic [DATA_W-1:0] mem [NWORDS];

  always_ff @(posedge clk) begin
    if (strobes.memWr) mem[strobes.wrAddr] <= pushData;
  end

  assign topData = strobes.topValid ? mem[strobes.rdAddr] : '0;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.memWr |=> (mem[$past(strobes.wrAddr)] == $past(pushData))); // R1
endmodule

// File: rtl/thread_stack_bank.sv
module thread_stack_bank
  import tsb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [TID_W-1:0]  thrdId,
  input  logic [SEL_W-1:0]  stkSel,
  input  logic              pushEn,
  input  logic              popEn,
  input  logic [DATA_W-1:0] pushData,
  input  logic              clrStacks,
  input  logic              errWrEn,
  input  logic [ERR_W-1:0]  errWrMask,
  output logic [DATA_W-1:0] topData,
  output logic [ERR_W-1:0]  errReg
);
  memStrobes_t strobes;

  tsb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .thrdId(thrdId), .stkSel(stkSel),
    .pushEn(pushEn), .popEn(popEn), .clrStacks(clrStacks),
    .errWrEn(errWrEn), .errWrMask(errWrMask),
    .strobes(strobes), .errReg(errReg)
  );

  tsb_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .pushData(pushData), .topData(topData)
  );
endmodule

// File: tb/tb_thread_stack_bank.sv
module tb_thread_stack_bank;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic [2:0] thrdId = '0;
  logic [1:0] stkSel = '0;
  logic pushEn = 0, popEn = 0, clrStacks = 0, errWrEn = 0;
  logic [31:0] pushData = '0;
  logic [15:0] errWrMask = '0;
  logic [31:0] topData;
  logic [15:0] errReg;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] mMem [1024];
  int          mLvl [32];
  logic [15:0] mErr;

  always #(CLK_PERIOD/2) clk = ~clk;

  thread_stack_bank dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expTop(input int t, input int s);
    int sl = t*4 + s;
    return (mLvl[sl] == 0) ? 32'h0 : mMem[sl*32 + mLvl[sl] - 1];
  endfunction

  task automatic cyc(input int t, input int s, input bit pu, input bit po,
                     input logic [31:0] d, input bit cl, input bit we,
                     input logic [15:0] mk, input string tag);
    int sl, lv;
    logic [15:0] sv;
    sl = t*4 + s; lv = mLvl[sl]; sv = '0;
    thrdId = 3'(t); stkSel = 2'(s); pushEn = pu; popEn = po;
    pushData = d; clrStacks = cl; errWrEn = we; errWrMask = mk;
    if (cl) begin
      for (int k = 0; k < 4; k++) mLvl[t*4 + k] = 0;
    end else if (pu && !po) begin
      if (lv == 32) sv[8 + t] = 1'b1;
      else begin mMem[sl*32 + lv] = d; mLvl[sl] = lv + 1; end
    end else if (po && !pu) begin
      if (lv == 0) sv[t] = 1'b1;
      else mLvl[sl] = lv - 1;
    end else if (po && pu) begin
      if (lv == 0) begin sv[t] = 1'b1; mMem[sl*32] = d; mLvl[sl] = 1; end
      else mMem[sl*32 + lv - 1] = d;
    end
    if (we) mErr = mErr & ~mk;
    mErr = mErr | sv;
    @(posedge clk);
    @(negedge clk);
    chk(errReg === mErr, {tag, " errReg"}, 32'(errReg), 32'(mErr));
    chk(topData === expTop(t, s), {tag, " topData"}, topData, expTop(t, s));
  endtask

  task automatic peek(input int t, input int s, input string tag);
    thrdId = 3'(t); stkSel = 2'(s); pushEn = 0; popEn = 0; clrStacks = 0; errWrEn = 0;
    #1;
    chk(topData === expTop(t, s), {tag, " peek topData"}, topData, expTop(t, s));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    for (int i = 0; i < 1024; i++) mMem[i] = '0;
    for (int i = 0; i < 32; i++) mLvl[i] = 0;
    mErr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    #1;
    chk(errReg === 16'h0, "R10 reset errReg", 32'(errReg), 0);
    chk(topData === 32'h0, "R10 reset topData", topData, 0);

    // R1 fill thread 2 stack 1
    for (int i = 0; i < 32; i++) cyc(2, 1, 1, 0, 32'hA000 + i, 0, 0, 0, "R1");
    chk(errReg === 16'h0, "R1 full no error", 32'(errReg), 0);
    chk(topData === 32'hA01F, "R1 top after fill", topData, 32'hA01F);
    // R2 push on full
    cyc(2, 1, 1, 0, 32'hDEAD, 0, 0, 0, "R2");
    chk(errReg === 16'h0400, "R2 push error bit", 32'(errReg), 32'h0400);
    chk(topData === 32'hA01F, "R2 contents kept", topData, 32'hA01F);
    // R6 clear it
    cyc(2, 1, 0, 0, 0, 0, 1, 16'h0400, "R6");
    chk(errReg === 16'h0, "R6 clear push bit", 32'(errReg), 0);
    // R3 swap on full
    cyc(2, 1, 1, 1, 32'hBEEF, 0, 0, 0, "R3");
    chk(topData === 32'hBEEF && errReg === 16'h0, "R3 swap on full", topData, 32'hBEEF);
    // R4 32 pops then underflow
    for (int i = 0; i < 32; i++) cyc(2, 1, 0, 1, 0, 0, 0, 0, "R4");
    chk(errReg === 16'h0 && topData === 32'h0, "R4 empty after 32 pops", 32'(errReg), 0);
    cyc(2, 1, 0, 1, 0, 0, 0, 0, "R4");
    chk(errReg === 16'h0004, "R4 pop error bit", 32'(errReg), 32'h0004);
    chk(topData === 32'h0, "R4 level stays zero", topData, 0);
    // R5 sticky across idle
    cyc(2, 1, 0, 0, 0, 0, 0, 0, "R5");
    chk(errReg === 16'h0004, "R5 sticky", 32'(errReg), 32'h0004);
    // R6 selective clear
    cyc(5, 0, 0, 1, 0, 0, 0, 0, "R6");
    cyc(5, 0, 0, 0, 0, 0, 1, 16'h0004, "R6");
    chk(errReg === 16'h0020, "R6 other bits kept", 32'(errReg), 32'h0020);
    // R7 set wins
    cyc(5, 0, 0, 1, 0, 0, 1, 16'h0020, "R7");
    chk(errReg === 16'h0020, "R7 set beats clear", 32'(errReg), 32'h0020);
    cyc(5, 0, 0, 0, 0, 0, 1, 16'hFFFF, "R6");
    chk(errReg === 16'h0, "R6 clear all", 32'(errReg), 0);
    // R4 push+pop on empty
    cyc(0, 3, 1, 1, 32'h1234, 0, 0, 0, "R4");
    chk(errReg === 16'h0001 && topData === 32'h1234, "R4 swap on empty", topData, 32'h1234);
    cyc(0, 3, 0, 0, 0, 0, 1, 16'hFFFF, "R6");
    // R8 clear thread 3
    for (int i = 0; i < 5; i++) cyc(3, 0, 1, 0, 32'h3000 + i, 0, 0, 0, "R8");
    for (int i = 0; i < 3; i++) cyc(3, 2, 1, 0, 32'h3200 + i, 0, 0, 0, "R8");
    for (int i = 0; i < 4; i++) cyc(4, 0, 1, 0, 32'h4000 + i, 0, 0, 0, "R9");
    cyc(3, 2, 1, 0, 32'h9999, 1, 0, 0, "R8");
    chk(topData === 32'h0, "R8 cleared selected", topData, 0);
    peek(3, 0, "R8");
    chk(topData === 32'h0, "R8 cleared sibling", topData, 0);
    peek(4, 0, "R8");
    chk(topData === 32'h4003, "R8 other thread kept", topData, 32'h4003);
    for (int i = 0; i < 32; i++) cyc(3, 0, 1, 0, 32'h5000 + i, 0, 0, 0, "R8");
    chk(errReg === 16'h0 && topData === 32'h501F, "R8 refill no error", 32'(errReg), 0);

    // R9 random mix against model
    for (int n = 0; n < 4000; n++) begin
      int t, s, r;
      bit pu, po, cl, we;
      t = $urandom_range(0, 7);
      s = $urandom_range(0, 3);
      r = $urandom_range(0, 99);
      pu = (r < 55); po = (r >= 35 && r < 80);
      cl = ($urandom_range(0, 99) < 2);
      we = ($urandom_range(0, 99) < 6);
      cyc(t, s, pu, po, $urandom, cl, we, 16'($urandom), "R9");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule